// File: doc/BRIEF.md
# Receive Byte DMA Channel

This block empties a serial receiver's data register into memory one byte at a time, without the CPU taking part. The receiver pulses a strobe each time a byte is complete. That pulse sets a ready flag. While the channel is enabled, has transfers left and holds a priority level above the CPU's current level, the flag raises a request. When the grant input answers the request, the block writes the byte to memory at the current pointer. It then advances the pointer, counts one transfer down and clears the ready flag.

Software programs a 16-bit destination pointer and an 8-bit transfer count while the channel is stopped, then enables it. The channel turns its own enable off and raises an end-of-block flag on its final transfer. That flag stays set until software clears it. Software can also stop the channel at any moment. A generate choice selects either a registered write port, with the write strobe one cycle after the grant edge, or a direct port that follows the grant combinationally.

Top module: `rxdma_channel`

## Requirements
- R1: During and right after reset, `chan_en`, `eob_pend`, `rx_ready`, `dma_req` and `mem_we` are all 0.
- R2: `dma_req` is 1 exactly when `rx_ready`, `chan_en` and a nonzero `xfer_cnt` hold together with the level condition of R11, and it stays 1 for as long as no grant arrives.
- R3: A rising clock edge with `dma_req` and `dma_gnt` both 1 is one transfer. In the default registered mode, `mem_we` is 1 for the single following cycle, with `mem_addr` equal to the pointer before the transfer and `mem_wdata` equal to `rx_data` at that edge. A grant held high yields only one write per received byte.
- R4: Each transfer adds one to `addr_ptr`, wrapping from 0xFFFF to 0x0000, and subtracts one from `xfer_cnt`.
- R5: A pulse on `rx_ready_set` sets `rx_ready`. A transfer clears it, and if both happen at the same edge the set wins.
- R6: The transfer that takes `xfer_cnt` from 1 to 0 sets `eob_pend` and clears `chan_en` at that same edge.
- R7: `sw_en_clr` clears `chan_en` at the next edge whatever else is happening. Afterwards `dma_req` is 0 and no write is issued.
- R8: Writes through `sw_addr_we` and `sw_cnt_we` take effect only while `chan_en` is 0. While the channel is enabled they leave `addr_ptr` and `xfer_cnt` unchanged.
- R9: `eob_pend` stays 1 until a cycle with `sw_eob_clr` at 1 clears it. A new end-of-block event at the same edge keeps it set.
- R10: Enabling the channel while `xfer_cnt` is 0 sets `chan_en` but never raises `dma_req`.
- R11: A request needs `chan_level` to be strictly greater, as an unsigned number, than `cpu_level`. With an equal or lower level, `dma_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ready_set | input | 1 | Pulse from the receiver: a new byte is in `rx_data` |
| rx_data | input | 8 | Receiver data register contents |
| sw_addr_we | input | 1 | Software load strobe for the pointer |
| sw_addr_wdata | input | 16 | Pointer value to load |
| sw_cnt_we | input | 1 | Software load strobe for the count |
| sw_cnt_wdata | input | 8 | Count value to load |
| sw_en_set | input | 1 | Software enable of the channel |
| sw_en_clr | input | 1 | Software stop of the channel |
| sw_eob_clr | input | 1 | Write-one-to-clear of the end-of-block flag |
| chan_level | input | 3 | Programmed priority level of the channel |
| cpu_level | input | 3 | Current priority level of the CPU |
| dma_gnt | input | 1 | Grant from the bus arbiter |
| dma_req | output | 1 | Request to the bus arbiter |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| rx_ready | output | 1 | Receive-ready flag |
| chan_en | output | 1 | Channel enable state |
| eob_pend | output | 1 | End-of-block pending flag |
| addr_ptr | output | 16 | Current destination pointer |
| xfer_cnt | output | 8 | Transfers remaining |

## Verification
The bench holds a request for several cycles with no grant. A design that dropped or timed out the request would lose the byte. It keeps the grant high across the final transfer, which shows up a design that writes twice or runs past the end of the block. It checks that the enable turns off and the pending flag turns on at that same edge, and that the pending flag survives idle cycles and a new byte. It enables with a zero count, which catches a counter that underflows into a 256-byte run. It also tries pointer and count loads while the channel runs, which catches loads that corrupt a running transfer. Finally it tests equal and lower priority levels, where an off-by-one comparison would grant, and a pointer at 0xFFFF, where a bad increment would not wrap to zero.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   // selects how the memory write port is built
   typedef enum logic {
      WPORT_REGISTERED = 1'b0,
      WPORT_DIRECT     = 1'b1
   } wport_mode_e;

   // one serviced request, as seen by the flag and pointer logic
   typedef struct packed {
      logic fire;   // request granted at this edge
      logic last;   // this is the final transfer of the block
   } xfer_evt_t;

endpackage

// File: rtl/rxdma_flags.sv
module rxdma_flags
   import rxdma_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rx_ready_set,
   input  xfer_evt_t evt,
   input  logic      sw_en_set,
   input  logic      sw_en_clr,
   input  logic      sw_eob_clr,
   output logic      ready_q,
   output logic      en_q,
   output logic      eob_q
);

   logic block_done;
   assign block_done = evt.fire & evt.last;

   // receive-ready: a new byte beats a completing transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ready_q <= 1'b0;
      else if (rx_ready_set) ready_q <= 1'b1;
      else if (evt.fire)     ready_q <= 1'b0;
   end

   // enable: software stop first, then hardware stop, then software start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          en_q <= 1'b0;
      else if (sw_en_clr)  en_q <= 1'b0;
      else if (block_done) en_q <= 1'b0;
      else if (sw_en_set)  en_q <= 1'b1;
   end

   // end-of-block pending: hardware set beats software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          eob_q <= 1'b0;
      else if (block_done) eob_q <= 1'b1;
      else if (sw_eob_clr) eob_q <= 1'b0;
   end

   // R5
   ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready_set |=> ready_q);

   // R6
   block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.fire && evt.last) |=> (eob_q && !en_q));

   // R7
   sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en_clr |=> !en_q);

   // R9
   eob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eob_q && !sw_eob_clr) |=> eob_q);

endmodule

// File: rtl/rxdma_ptr.sv
module rxdma_ptr #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fire,
   input  logic              sw_addr_we,
   input  logic [ADDR_W-1:0] sw_addr_wdata,
   input  logic              sw_cnt_we,
   input  logic [CNT_W-1:0]  sw_cnt_wdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              cnt_zero,
   output logic              cnt_last
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   logic load_ok;
   assign load_ok = ~en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    addr_q <= '0;
      else if (fire)                 addr_q <= addr_q + ADDR_ONE;
      else if (load_ok & sw_addr_we) addr_q <= sw_addr_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (fire)                cnt_q <= cnt_q - CNT_ONE;
      else if (load_ok & sw_cnt_we) cnt_q <= sw_cnt_wdata;
   end

   assign cnt_zero = (cnt_q == '0);
   assign cnt_last = (cnt_q == CNT_ONE);

   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_ONE)) &&
               (cnt_q == CNT_W'($past(cnt_q) - CNT_ONE)));

   // R8
   locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !fire && (sw_addr_we || sw_cnt_we)) |=> ($stable(addr_q) && $stable(cnt_q)));

endmodule

// File: rtl/rxdma_wport.sv
module rxdma_wport
   import rxdma_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter int          DATA_W = 8,
   parameter wport_mode_e MODE   = WPORT_REGISTERED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata
);

   generate
      if (MODE == WPORT_REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               we    <= 1'b0;
               waddr <= '0;
               wdata <= '0;
            end else begin
               we <= fire;
               if (fire) begin
                  waddr <= addr;
                  wdata <= data;
               end
            end
         end

         // R3
         write_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we |-> $past(fire));

         // R3
         write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (we && waddr == $past(addr) && wdata == $past(data)));
      end else begin : g_direct
         assign we    = fire;
         assign waddr = addr;
         assign wdata = data;
      end
   endgenerate

endmodule

// File: rtl/rxdma_channel.sv
module rxdma_channel
   import rxdma_pkg::*;
#(
   parameter int          ADDR_W = 16,
   parameter int          CNT_W  = 8,
   parameter int          DATA_W = 8,
   parameter int          PRIO_W = 3,
   parameter wport_mode_e WPORT  = WPORT_REGISTERED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_ready_set,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              sw_addr_we,
   input  logic [ADDR_W-1:0] sw_addr_wdata,
   input  logic              sw_cnt_we,
   input  logic [CNT_W-1:0]  sw_cnt_wdata,
   input  logic              sw_en_set,
   input  logic              sw_en_clr,
   input  logic              sw_eob_clr,
   input  logic [PRIO_W-1:0] chan_level,
   input  logic [PRIO_W-1:0] cpu_level,
   input  logic              dma_gnt,
   output logic              dma_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              rx_ready,
   output logic              chan_en,
   output logic              eob_pend,
   output logic [ADDR_W-1:0] addr_ptr,
   output logic [CNT_W-1:0]  xfer_cnt
);

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr
         $error("rxdma_channel: ADDR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("rxdma_channel: CNT_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("rxdma_channel: DATA_W must be positive");
      end
      if (PRIO_W < 1) begin : g_bad_prio
         $error("rxdma_channel: PRIO_W must be positive");
      end
   endgenerate

   logic      ready_q, en_q, eob_q;
   logic      cnt_zero, cnt_last;
   logic      level_ok;
   xfer_evt_t evt;

   assign level_ok  = (chan_level > cpu_level);
   assign dma_req   = ready_q & en_q & ~cnt_zero & level_ok;
   assign evt.fire  = dma_req & dma_gnt;
   assign evt.last  = cnt_last;

   rxdma_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_ready_set (rx_ready_set),
      .evt          (evt),
      .sw_en_set    (sw_en_set),
      .sw_en_clr    (sw_en_clr),
      .sw_eob_clr   (sw_eob_clr),
      .ready_q      (ready_q),
      .en_q         (en_q),
      .eob_q        (eob_q)
   );

   rxdma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en_q),
      .fire          (evt.fire),
      .sw_addr_we    (sw_addr_we),
      .sw_addr_wdata (sw_addr_wdata),
      .sw_cnt_we     (sw_cnt_we),
      .sw_cnt_wdata  (sw_cnt_wdata),
      .addr_q        (addr_ptr),
      .cnt_q         (xfer_cnt),
      .cnt_zero      (cnt_zero),
      .cnt_last      (cnt_last)
   );

   rxdma_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(WPORT)) u_wport (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (evt.fire),
      .addr  (addr_ptr),
      .data  (rx_data),
      .we    (mem_we),
      .waddr (mem_addr),
      .wdata (mem_wdata)
   );

   assign rx_ready = ready_q;
   assign chan_en  = en_q;
   assign eob_pend = eob_q;

   // R10
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_cnt == '0) |-> !dma_req);

   // R11
   level_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_level <= cpu_level) |-> !dma_req);

   // R7
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |-> !dma_req);

endmodule

// File: tb/rxdma_channel_test.sv
`timescale 1ns/1ps
module rxdma_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_ready_set = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        sw_addr_we = 1'b0;
   logic [15:0] sw_addr_wdata = '0;
   logic        sw_cnt_we = 1'b0;
   logic [7:0]  sw_cnt_wdata = '0;
   logic        sw_en_set = 1'b0;
   logic        sw_en_clr = 1'b0;
   logic        sw_eob_clr = 1'b0;
   logic [2:0]  chan_level = 3'd3;
   logic [2:0]  cpu_level = 3'd0;
   logic        dma_gnt = 1'b0;
   logic        dma_req, mem_we, rx_ready, chan_en, eob_pend;
   logic [15:0] mem_addr, addr_ptr;
   logic [7:0]  mem_wdata, xfer_cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rxdma_channel uut (
      .clk(clk), .rst_n(rst_n), .rx_ready_set(rx_ready_set), .rx_data(rx_data),
      .sw_addr_we(sw_addr_we), .sw_addr_wdata(sw_addr_wdata),
      .sw_cnt_we(sw_cnt_we), .sw_cnt_wdata(sw_cnt_wdata),
      .sw_en_set(sw_en_set), .sw_en_clr(sw_en_clr), .sw_eob_clr(sw_eob_clr),
      .chan_level(chan_level), .cpu_level(cpu_level), .dma_gnt(dma_gnt),
      .dma_req(dma_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .rx_ready(rx_ready), .chan_en(chan_en), .eob_pend(eob_pend),
      .addr_ptr(addr_ptr), .xfer_cnt(xfer_cnt)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // one clock: rising edge, then back to the falling edge where we drive and sample
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sw_load(input logic [15:0] a, input logic [7:0] c);
      sw_addr_we = 1'b1; sw_addr_wdata = a;
      sw_cnt_we  = 1'b1; sw_cnt_wdata  = c;
      step();
      sw_addr_we = 1'b0; sw_cnt_we = 1'b0;
   endtask

   task automatic sw_enable();
      sw_en_set = 1'b1; step(); sw_en_set = 1'b0;
   endtask

   task automatic sw_disable();
      sw_en_clr = 1'b1; step(); sw_en_clr = 1'b0;
   endtask

   task automatic push_byte(input logic [7:0] d);
      rx_data = d; rx_ready_set = 1'b1; step(); rx_ready_set = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "chan_en", chan_en, 0);
      check("R1", "eob_pend", eob_pend, 0);
      check("R1", "rx_ready", rx_ready, 0);
      check("R1", "dma_req", dma_req, 0);
      check("R1", "mem_we", mem_we, 0);
   endtask

   task automatic t_first_transfer();
      sw_load(16'h1230, 8'd3);
      sw_enable();
      check("R2", "req without byte", dma_req, 0);
      push_byte(8'hA5);
      check("R5", "ready after byte", rx_ready, 1);
      check("R2", "req raised", dma_req, 1);
      for (int i = 0; i < 3; i++) step();
      check("R2", "req held without grant", dma_req, 1);
      check("R3", "no write without grant", mem_we, 0);
      dma_gnt = 1'b1; step(); dma_gnt = 1'b0;
      check("R3", "write strobe", mem_we, 1);
      check("R3", "write addr", mem_addr, 16'h1230);
      check("R3", "write data", mem_wdata, 8'hA5);
      check("R5", "ready cleared", rx_ready, 0);
      check("R2", "req dropped", dma_req, 0);
      check("R4", "ptr incremented", addr_ptr, 16'h1231);
      check("R4", "count decremented", xfer_cnt, 8'd2);
      step();
      check("R3", "strobe one cycle", mem_we, 0);
   endtask

   task automatic t_block_end();
      push_byte(8'h11);
      dma_gnt = 1'b1; step(); dma_gnt = 1'b0;
      check("R3", "second write data", mem_wdata, 8'h11);
      push_byte(8'h22);
      dma_gnt = 1'b1; step();
      check("R6", "eob set at last", eob_pend, 1);
      check("R6", "enable cleared at last", chan_en, 0);
      check("R4", "count at zero", xfer_cnt, 8'd0);
      check("R4", "ptr after block", addr_ptr, 16'h1233);
      check("R3", "last write addr", mem_addr, 16'h1232);
      step(); dma_gnt = 1'b0;
      check("R3", "held grant no extra write", mem_we, 0);
      for (int i = 0; i < 4; i++) step();
      check("R9", "eob held", eob_pend, 1);
      push_byte(8'h33);
      check("R6", "no req after block", dma_req, 0);
      check("R9", "eob held after byte", eob_pend, 1);
      sw_eob_clr = 1'b1; step(); sw_eob_clr = 1'b0;
      check("R9", "eob cleared by software", eob_pend, 0);
   endtask

   task automatic t_zero_and_lock();
      sw_enable();
      check("R10", "enabled with zero count", chan_en, 1);
      check("R10", "no req with zero count", dma_req, 0);
      sw_load(16'h4000, 8'd9);
      check("R8", "ptr load ignored", addr_ptr, 16'h1233);
      check("R8", "count load ignored", xfer_cnt, 8'd0);
      sw_disable();
      check("R7", "stopped", chan_en, 0);
      sw_load(16'h4000, 8'd9);
      check("R8", "ptr load while stopped", addr_ptr, 16'h4000);
      check("R8", "count load while stopped", xfer_cnt, 8'd9);
   endtask

   task automatic t_stop_pending();
      sw_enable();
      check("R2", "pending byte requests", dma_req, 1);
      sw_disable();
      check("R7", "enable cleared", chan_en, 0);
      check("R7", "req cleared", dma_req, 0);
      check("R7", "no write", mem_we, 0);
      check("R7", "count unchanged", xfer_cnt, 8'd9);
   endtask

   task automatic t_levels();
      cpu_level = 3'd5;
      sw_enable();
      check("R11", "lower level blocked", dma_req, 0);
      cpu_level = 3'd3;
      step();
      check("R11", "equal level blocked", dma_req, 0);
      cpu_level = 3'd2;
      step();
      check("R11", "higher level requests", dma_req, 1);
      dma_gnt = 1'b1; step(); dma_gnt = 1'b0;
      check("R11", "write after level ok", mem_addr, 16'h4000);
      cpu_level = 3'd0;
   endtask

   task automatic t_wrap();
      sw_disable();
      sw_load(16'hFFFF, 8'd2);
      sw_enable();
      push_byte(8'h5C);
      dma_gnt = 1'b1; step(); dma_gnt = 1'b0;
      check("R4", "write at top address", mem_addr, 16'hFFFF);
      check("R4", "ptr wraps", addr_ptr, 16'h0000);
      check("R4", "count after wrap", xfer_cnt, 8'd1);
      check("R6", "not yet end of block", eob_pend, 0);
   endtask

   task automatic t_set_beats_clear();
      // byte arrives at the same edge as the granted transfer
      push_byte(8'h77);
      rx_data = 8'h78; rx_ready_set = 1'b1; dma_gnt = 1'b1; step();
      rx_ready_set = 1'b0; dma_gnt = 1'b0;
      check("R5", "set wins over clear", rx_ready, 1);
      check("R6", "final transfer done", eob_pend, 1);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      check("R1", "req in reset", dma_req, 0);
      step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_first_transfer();
      t_block_end();
      t_zero_and_lock();
      t_stop_pending();
      t_levels();
      t_wrap();
      t_set_beats_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule